// File: doc/BRIEF.md
# Multiplexed ADC Conversion Sequencer

This block sits between a 16-bit register port and a multiplexed analog-to-digital converter. Software starts a single conversion by writing the control word with the go bit set and a channel number in its channel field. The sequencer then steers the converter's multiplexer to that channel. If the channel differs from the one used last time, or if software asks for it, the sequencer waits a mux-settling interval of about 15 us. It then pulses the convert strobe for one cycle and waits for the converter to return a data-valid pulse.

The returned 16-bit sample is latched into the result register. An end-of-conversion flag then rises in the status register, and it stays up until software writes a 1 to it. Ten channels can be selected: codes 0 to 7 are differential inputs, code 8 is the +10 V reference and code 9 is the 0 V reference. A busy bit in the control readback lets software poll for progress. The converter is treated as a fixed-latency handshake that lies outside this block.

The controller is a four-state machine:
- **IDLE** waits for an accepted start.
- **SETTLE** counts out the settling interval.
- **STROBE** drives the one-cycle convert pulse.
- **AWAIT** waits for data-valid.

The transitions are:
- **start_settle**: IDLE to SETTLE, when a start is accepted and settling is needed.
- **start_direct**: IDLE to STROBE, when a start is accepted and no settling is needed.
- **settle_done**: SETTLE to STROBE, when the interval expires.
- **strobe_sent**: STROBE to AWAIT, always.
- **sample_back**: AWAIT to IDLE, when data-valid arrives.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset the convert strobe is low, the result register (offset 0x08) reads 0, the status register (offset 0x0E) reads 0 and the busy bit (bit 0 of a read at control offset 0x06) is 0.
- R2: A write to offset 0x06 with bit 0 set, channel code in bits 4:1 equal to the previously converted channel and bit 15 clear drives the convert strobe high for exactly one cycle, starting in the cycle after the write edge.
- R3: When bit 15 of the start write is set, the strobe is delayed by SETTLE_CYC = CLK_MHZ*SETTLE_US cycles (1875 at 125 MHz), even if the channel is unchanged.
- R4: The same settling delay is applied without bit 15 when the channel code differs from the previously converted channel, and on the first conversion after reset; adc_mux_sel shows the new channel code.
- R5: A data-valid pulse while awaiting the sample latches adc_data into the result register (offset 0x08) and sets bit 2 of the status register, both visible from the next cycle.
- R6: The busy bit reads 1 from the cycle after an accepted start until the cycle after the sample is latched, then reads 0.
- R7: A start written while busy is ignored: no extra strobe is produced and adc_mux_sel is unchanged.
- R8: Writing 1 to status bit 2 clears the end-of-conversion flag; writing 0 there leaves it unchanged.
- R9: If a clearing write and a completion fall on the same cycle, the flag stays set.
- R10: The result register holds its value until the next completion; a data-valid pulse outside the awaiting state is ignored and does not set the flag.
- R11: A start naming a channel code of 10 or more is ignored: no strobe, busy stays 0 and adc_mux_sel keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 6 | Byte offset of the write |
| reg_wr_data | input | 16 | Write data |
| reg_rd_addr | input | 6 | Byte offset of the read |
| reg_rd_data | output | 16 | Read data (combinational) |
| adc_mux_sel | output | 4 | Channel code driven to the input multiplexer |
| adc_convert | output | 1 | One-cycle convert strobe |
| adc_data_valid | input | 1 | Converter result-ready pulse |
| adc_data | input | 16 | Converter sample |

## Verification
The strobe is due in the cycle right after the write edge when no settling is needed. With settling it comes exactly SETTLE_CYC cycles later. The result, the flag and the busy drop all become visible one cycle after the data-valid edge. The bench drives every input on a falling edge, so each stimulus is taken at the next rising edge. It samples on falling edges by counting the edges between stimulus and result. For the delayed case it checks that the strobe stays low in every cycle before SETTLE_CYC and is high exactly at SETTLE_CYC.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_STROBE = 2'd2,
        ST_AWAIT  = 2'd3
    } seq_state_t;

    localparam int REG_ADDR_W = 6;
    localparam int REG_W      = 16;
    localparam int CH_W       = 4;

    localparam logic [REG_ADDR_W-1:0] OFS_CTRL   = 6'h06;
    localparam logic [REG_ADDR_W-1:0] OFS_RESULT = 6'h08;
    localparam logic [REG_ADDR_W-1:0] OFS_STATUS = 6'h0E;

    localparam int CTRL_GO_BIT     = 0;
    localparam int CTRL_CH_LSB     = 1;
    localparam int CTRL_SETTLE_BIT = 15;
    localparam int STAT_EOC_BIT    = 2;

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
    parameter int CYC = 1875
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int CNT_W = (CYC > 1) ? $clog2(CYC + 1) : 1;
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_req,
    input  logic [CH_W-1:0] req_chan,
    input  logic            req_settle,
    input  logic            adc_data_valid,
    input  logic            settle_expired,
    output logic            settle_load,
    output logic            busy,
    output logic            done,
    output logic            adc_convert,
    output logic [CH_W-1:0] mux_sel
);
    seq_state_t state_q, state_d;
    logic       chan_known_q;
    logic       accept;
    logic       need_settle;

    assign accept      = (state_q == ST_IDLE) && start_req;
    assign need_settle = req_settle || !chan_known_q || (req_chan != mux_sel);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = need_settle ? ST_SETTLE : ST_STROBE;
            ST_SETTLE: if (settle_expired) state_d = ST_STROBE;
            ST_STROBE: state_d = ST_AWAIT;
            ST_AWAIT:  if (adc_data_valid) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and channel memory
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            chan_known_q <= 1'b0;
            mux_sel      <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                chan_known_q <= 1'b1;
                mux_sel      <= req_chan;
            end
        end
    end

    // outputs
    always_comb begin
        adc_convert = 1'b0;
        busy        = 1'b1;
        done        = 1'b0;
        settle_load = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy        = 1'b0;
                settle_load = accept && need_settle;
            end
            ST_SETTLE: ;
            ST_STROBE: adc_convert = 1'b1;
            ST_AWAIT:  done = adc_data_valid;
            default:   busy = 1'b0;
        endcase
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        adc_convert |=> !adc_convert); // R2
    AST_SETTLE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE && settle_expired) |=> adc_convert); // R3
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_req) |=> $stable(mux_sel)); // R7
    AST_MUX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(mux_sel) < NUM_CH); // R11

endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH = 10,
    parameter int DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]      wr_data,
    input  logic [REG_ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]      rd_data,
    input  logic                  busy,
    input  logic                  done,
    input  logic [DATA_W-1:0]     sample,
    input  logic [CH_W-1:0]       mux_sel,
    output logic                  start_req,
    output logic [CH_W-1:0]       req_chan,
    output logic                  req_settle
);
    logic              eoc_q;
    logic              settle_last_q;
    logic [DATA_W-1:0] result_q;
    logic              ctrl_wr;
    logic              eoc_clr;

    assign ctrl_wr    = wr_en && (wr_addr == OFS_CTRL);
    assign req_chan   = wr_data[CTRL_CH_LSB +: CH_W];
    assign req_settle = wr_data[CTRL_SETTLE_BIT];
    assign start_req  = ctrl_wr && wr_data[CTRL_GO_BIT] && (int'(req_chan) < NUM_CH);
    assign eoc_clr    = wr_en && (wr_addr == OFS_STATUS) && wr_data[STAT_EOC_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoc_q         <= 1'b0;
            settle_last_q <= 1'b0;
            result_q      <= '0;
        end else begin
            if (done) begin
                eoc_q    <= 1'b1;
                result_q <= sample;
            end else if (eoc_clr) begin
                eoc_q <= 1'b0;
            end
            if (start_req && !busy) settle_last_q <= req_settle;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            OFS_CTRL: begin
                rd_data[CTRL_GO_BIT]            = busy;
                rd_data[CTRL_CH_LSB +: CH_W]    = mux_sel;
                rd_data[CTRL_SETTLE_BIT]        = settle_last_q;
            end
            OFS_RESULT: rd_data[DATA_W-1:0]     = result_q;
            OFS_STATUS: rd_data[STAT_EOC_BIT]   = eoc_q;
            default:    rd_data = '0;
        endcase
    end

    AST_EOC_COMPLETION_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> eoc_q); // R9
    AST_EOC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc_clr && !done) |=> !eoc_q); // R8
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(result_q)); // R10

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_seq_pkg::*;
#(
    parameter int CLK_MHZ   = 125,
    parameter int SETTLE_US = 15,
    parameter int NUM_CH    = 10,
    parameter int DATA_W    = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr_en,
    input  logic [REG_ADDR_W-1:0] reg_wr_addr,
    input  logic [REG_W-1:0]      reg_wr_data,
    input  logic [REG_ADDR_W-1:0] reg_rd_addr,
    output logic [REG_W-1:0]      reg_rd_data,
    output logic [CH_W-1:0]       adc_mux_sel,
    output logic                  adc_convert,
    input  logic                  adc_data_valid,
    input  logic [DATA_W-1:0]     adc_data
);
    localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;

    logic            start_req;
    logic [CH_W-1:0] req_chan;
    logic            req_settle;
    logic            busy;
    logic            done;
    logic            settle_load;
    logic            settle_expired;

    adc_seq_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .wr_addr    (reg_wr_addr),
        .wr_data    (reg_wr_data),
        .rd_addr    (reg_rd_addr),
        .rd_data    (reg_rd_data),
        .busy       (busy),
        .done       (done),
        .sample     (adc_data),
        .mux_sel    (adc_mux_sel),
        .start_req  (start_req),
        .req_chan   (req_chan),
        .req_settle (req_settle)
    );

    adc_seq_fsm #(.NUM_CH(NUM_CH)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_req      (start_req),
        .req_chan       (req_chan),
        .req_settle     (req_settle),
        .adc_data_valid (adc_data_valid),
        .settle_expired (settle_expired),
        .settle_load    (settle_load),
        .busy           (busy),
        .done           (done),
        .adc_convert    (adc_convert),
        .mux_sel        (adc_mux_sel)
    );

    adc_seq_timer #(.CYC(SETTLE_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (settle_load),
        .expired (settle_expired)
    );

endmodule

// File: tb/adc_conv_seq_tb.sv
module adc_conv_seq_tb;
    localparam int SETTLE_CYC = 125 * 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [5:0]  reg_wr_addr = '0;
    logic [15:0] reg_wr_data = '0;
    logic [5:0]  reg_rd_addr = '0;
    logic [15:0] reg_rd_data;
    logic [3:0]  adc_mux_sel;
    logic        adc_convert;
    logic        adc_data_valid = 1'b0;
    logic [15:0] adc_data = '0;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    adc_conv_seq u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .reg_wr_en      (reg_wr_en),
        .reg_wr_addr    (reg_wr_addr),
        .reg_wr_data    (reg_wr_data),
        .reg_rd_addr    (reg_rd_addr),
        .reg_rd_data    (reg_rd_data),
        .adc_mux_sel    (adc_mux_sel),
        .adc_convert    (adc_convert),
        .adc_data_valid (adc_data_valid),
        .adc_data       (adc_data)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] addr, logic [15:0] data);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = addr; reg_wr_data = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(logic [5:0] addr, output logic [15:0] data);
        reg_rd_addr = addr;
        #1;
        data = reg_rd_data;
    endtask

    task automatic valid_pulse(logic [15:0] d);
        @(negedge clk);
        adc_data_valid = 1'b1; adc_data = d;
        @(negedge clk);
        adc_data_valid = 1'b0;
    endtask

    task automatic expect_strobe_at(int n, string req);
        int early = 0;
        for (int k = 0; k < n; k++) begin
            if (adc_convert) early++;
            @(negedge clk);
        end
        check(req, "strobe before due cycle", early, 0);
        check(req, "strobe at due cycle", adc_convert, 1);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R1", "convert after reset", adc_convert, 0);
        rd(6'h08, v); check("R1", "result after reset", v, 16'h0000);
        rd(6'h0E, v); check("R1", "status after reset", v, 16'h0000);
        rd(6'h06, v); check("R1", "busy after reset", v[0], 0);
    endtask

    task automatic t_first_change();
        logic [15:0] v;
        wr(6'h06, 16'h0007);               // go, channel 3
        rd(6'h06, v); check("R6", "busy after start", v[0], 1);
        expect_strobe_at(SETTLE_CYC, "R4");
        check("R4", "mux select", adc_mux_sel, 3);
        valid_pulse(16'h1234);
        rd(6'h08, v); check("R5", "result latched", v, 16'h1234);
        rd(6'h0E, v); check("R5", "eoc flag set", v, 16'h0004);
        rd(6'h06, v); check("R6", "busy cleared", v[0], 0);
    endtask

    task automatic t_clear();
        logic [15:0] v;
        wr(6'h0E, 16'h0000);
        rd(6'h0E, v); check("R8", "write 0 keeps flag", v, 16'h0004);
        wr(6'h0E, 16'h0004);
        rd(6'h0E, v); check("R8", "write 1 clears flag", v, 16'h0000);
    endtask

    task automatic t_same_channel();
        logic [15:0] v;
        wr(6'h06, 16'h0007);
        expect_strobe_at(0, "R2");
        @(negedge clk);
        check("R2", "strobe lasts one cycle", adc_convert, 0);
        valid_pulse(16'hBEEF);
        rd(6'h08, v); check("R5", "second result", v, 16'hBEEF);
    endtask

    task automatic t_forced_settle();
        logic [15:0] v;
        wr(6'h06, 16'h8007);
        expect_strobe_at(SETTLE_CYC, "R3");
        valid_pulse(16'h0F0F);
        rd(6'h08, v); check("R3", "result after settle", v, 16'h0F0F);
        wr(6'h0E, 16'h0004);
    endtask

    task automatic t_busy_and_coincide();
        logic [15:0] v;
        wr(6'h06, 16'h0013);               // channel 9
        expect_strobe_at(SETTLE_CYC, "R4");
        check("R4", "mux select ref", adc_mux_sel, 9);
        @(negedge clk);                    // now awaiting sample
        wr(6'h06, 16'h000B);               // start channel 5 while busy
        check("R7", "no strobe for busy start", adc_convert, 0);
        check("R7", "mux unchanged", adc_mux_sel, 9);
        @(negedge clk);
        check("R7", "still no strobe", adc_convert, 0);
        rd(6'h08, v); check("R10", "result held during conversion", v, 16'h0F0F);
        // completion and clear on the same edge
        adc_data_valid = 1'b1; adc_data = 16'h5A5A;
        reg_wr_en = 1'b1; reg_wr_addr = 6'h0E; reg_wr_data = 16'h0004;
        @(negedge clk);
        adc_data_valid = 1'b0; reg_wr_en = 1'b0;
        rd(6'h0E, v); check("R9", "completion wins over clear", v, 16'h0004);
        rd(6'h08, v); check("R5", "result on coincidence", v, 16'h5A5A);
    endtask

    task automatic t_stray_valid();
        logic [15:0] v;
        wr(6'h0E, 16'h0004);
        valid_pulse(16'hDEAD);
        rd(6'h08, v); check("R10", "stray valid ignored", v, 16'h5A5A);
        rd(6'h0E, v); check("R10", "no flag from stray valid", v, 16'h0000);
    endtask

    task automatic t_bad_channel();
        logic [15:0] v;
        int seen = 0;
        wr(6'h06, 16'h0019);               // channel 12
        rd(6'h06, v); check("R11", "busy stays low", v[0], 0);
        for (int k = 0; k < SETTLE_CYC + 4; k++) begin
            if (adc_convert) seen++;
            @(negedge clk);
        end
        check("R11", "no strobe for bad channel", seen, 0);
        check("R11", "mux unchanged", adc_mux_sel, 9);
    endtask

    initial begin
        #(200000 * 8);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_change();
        t_clear();
        t_same_channel();
        t_forced_settle();
        t_busy_and_coincide();
        t_stray_valid();
        t_bad_channel();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule